// File: doc/BRIEF.md
# Unlock-sequence command decoder

This block sits between a host write port and the operation engine of a flash-style memory. It watches host write cycles, each one an address and a data byte. It recognises command sequences, and each sequence must open with two fixed unlock writes. When a sequence completes, the block turns it into a one-cycle start pulse for the engine. The pulses cover page program, chip erase, sector erase, suspend, resume, clear status and abort. The block also keeps track of which source a host read should return: the array, the status word or the identification bytes.

A sequence has three writes in the normal case. The first two are unlock writes and the third carries the command byte. An erase sequence has six writes: the third carries a setup byte, two more unlock writes follow, and the sixth write chooses between chip erase and sector erase. For a sector erase, the sector number is taken from the upper address bits of that sixth write. The engine reports whether a program is running, an erase is running, or an erase is suspended. The decoder uses that state to narrow the set of commands it acts on. A write that does not fit the expected sequence returns the decoder to its idle state and starts nothing.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: After reset, read_mode_o is 0 (array), every pulse output is low and sector_o is 0.
- R2: When the engine is idle, data AAh to unlock address A (low 15 bits 5555h), then 55h to unlock address B (low 15 bits 2AAAh), then a command byte to address A completes a command. Its effect is visible on the outputs in the cycle after the third write is sampled. F0h sets read mode 0 (array). 90h sets read mode 2 (id). A0h pulses prog_start_o and sets read mode 1 (status). 70h sets read mode 1. 50h pulses clr_status_o. E0h pulses abort_o and sets read mode 0.
- R3: Only address bits 14:0 are compared against the unlock addresses. Bits 20:15 have no effect on recognition.
- R4: When the engine is idle, setup byte 80h followed by AAh to A, 55h to B and 10h to A pulses chip_erase_o and sets read mode 1.
- R5: When the engine is idle, setup byte 80h followed by AAh to A, 55h to B and 30h to any address pulses sect_erase_o, sets read mode 1 and loads sector_o with address bits 20:16 of the last write. sector_o changes at no other time.
- R6: A write whose address or data does not match the expected step returns the decoder to idle. No pulse fires and the read mode is kept.
- R7: While prog_busy_i is high, erase is not running and erase is not suspended, only 70h is acted on. No pulse fires, and F0h leaves the read mode unchanged.
- R8: While erase_busy_i is high and erase_susp_i is low, only 70h and B0h are acted on. B0h pulses suspend_o and sets read mode 1.
- R9: While erase_susp_i is high, only F0h, 70h, E0h and D0h are acted on. D0h pulses resume_o and sets read mode 1.
- R10: id_data_o is C2h when id_sel_i is 0 and F9h when id_sel_i is 1.
- R11: At most one pulse output is high in any cycle, and each pulse lasts exactly one cycle.
- R12: 50h leaves the read mode unchanged. The 80h setup byte is dropped, with the decoder returning to idle, unless the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_addr_i | input | 21 | Write address |
| wr_data_i | input | 8 | Write data byte |
| prog_busy_i | input | 1 | Engine is running a program |
| erase_busy_i | input | 1 | Engine is running an erase |
| erase_susp_i | input | 1 | Engine erase is suspended |
| id_sel_i | input | 1 | Identification byte offset |
| read_mode_o | output | 2 | 0 array, 1 status, 2 id |
| id_data_o | output | 8 | Identification byte |
| prog_start_o | output | 1 | Page program start pulse |
| chip_erase_o | output | 1 | Chip erase start pulse |
| sect_erase_o | output | 1 | Sector erase start pulse |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |
| clr_status_o | output | 1 | Clear status pulse |
| abort_o | output | 1 | Abort pulse |
| sector_o | output | 5 | Sector captured by the last sector erase |

## Verification
The pulses, read_mode_o and sector_o all come from one register stage. They are due in the cycle after the clock edge that samples the final write of a sequence, and they must drop again one cycle later. id_data_o is combinational and is due in the same cycle as id_sel_i. The bench drives each write at a falling edge and checks the registered results at the next falling edge. At that point exactly one rising edge has passed, so the expected pulse, mode and sector are compared there. A further falling-edge sample confirms that every pulse has cleared.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_ID     = 2'd2
  } rmode_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RESET,
    OP_ID,
    OP_PROG,
    OP_CHIP,
    OP_SECT,
    OP_SUSP,
    OP_RESUME,
    OP_STATUS,
    OP_CLEAR,
    OP_ABORT
  } op_e;

  localparam logic [7:0] UNL_DATA_A = 8'hAA;
  localparam logic [7:0] UNL_DATA_B = 8'h55;

  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_ID     = 8'h90;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_SETUP  = 8'h80;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'hD0;
  localparam logic [7:0] C_STATUS = 8'h70;
  localparam logic [7:0] C_CLEAR  = 8'h50;
  localparam logic [7:0] C_ABORT  = 8'hE0;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;

  // pulse vector bit positions
  localparam int PB_PROG   = 0;
  localparam int PB_CHIP   = 1;
  localparam int PB_SECT   = 2;
  localparam int PB_SUSP   = 3;
  localparam int PB_RESUME = 4;
  localparam int PB_CLEAR  = 5;
  localparam int PB_ABORT  = 6;
  localparam int PULSE_N   = 7;

endpackage

// File: rtl/cmdec_seq.sv
module cmdec_seq
  import cmdec_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int CMP_W    = 15,
  parameter logic [CMP_W-1:0] UNL_ADDR_A = 15'h5555,
  parameter logic [CMP_W-1:0] UNL_ADDR_B = 15'h2AAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              setup_ok_i,
  output logic              fire_o,
  output op_e               op_o
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_ESET,
    ST_EUNL1,
    ST_EUNL2
  } seq_e;

  seq_e state_q, state_d;
  logic hit_a, hit_b;
  logic unused_addr;

  assign hit_a = (addr_i[CMP_W-1:0] == UNL_ADDR_A);
  assign hit_b = (addr_i[CMP_W-1:0] == UNL_ADDR_B);
  assign unused_addr = ^addr_i[ADDR_W-1:CMP_W];

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    op_o    = OP_NONE;
    if (wr_en_i) begin
      state_d = ST_IDLE;
      case (state_q)
        ST_IDLE:  if (hit_a && data_i == UNL_DATA_A) state_d = ST_UNL1;
        ST_UNL1:  if (hit_b && data_i == UNL_DATA_B) state_d = ST_UNL2;
        ST_UNL2: begin
          if (hit_a) begin
            case (data_i)
              C_RESET:  begin fire_o = 1'b1; op_o = OP_RESET;  end
              C_ID:     begin fire_o = 1'b1; op_o = OP_ID;     end
              C_PROG:   begin fire_o = 1'b1; op_o = OP_PROG;   end
              C_SUSP:   begin fire_o = 1'b1; op_o = OP_SUSP;   end
              C_RESUME: begin fire_o = 1'b1; op_o = OP_RESUME; end
              C_STATUS: begin fire_o = 1'b1; op_o = OP_STATUS; end
              C_CLEAR:  begin fire_o = 1'b1; op_o = OP_CLEAR;  end
              C_ABORT:  begin fire_o = 1'b1; op_o = OP_ABORT;  end
              C_SETUP:  if (setup_ok_i) state_d = ST_ESET;
              default:  state_d = ST_IDLE;
            endcase
          end
        end
        ST_ESET:  if (hit_a && data_i == UNL_DATA_A) state_d = ST_EUNL1;
        ST_EUNL1: if (hit_b && data_i == UNL_DATA_B) state_d = ST_EUNL2;
        ST_EUNL2: begin
          if (hit_a && data_i == C_CHIP) begin
            fire_o = 1'b1; op_o = OP_CHIP;
          end else if (data_i == C_SECT) begin
            fire_o = 1'b1; op_o = OP_SECT;
          end
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/cmdec_gate.sv
module cmdec_gate
  import cmdec_pkg::*;
(
  input  op_e  op_i,
  input  logic prog_busy_i,
  input  logic erase_busy_i,
  input  logic erase_susp_i,
  output logic ok_o,
  output logic setup_ok_o
);

  assign setup_ok_o = !prog_busy_i && !erase_busy_i && !erase_susp_i;

  // precedence: suspended, then erasing, then programming, then idle
  always_comb begin
    ok_o = 1'b0;
    if (erase_susp_i) begin
      case (op_i)
        OP_RESET, OP_STATUS, OP_ABORT, OP_RESUME: ok_o = 1'b1;
        default: ok_o = 1'b0;
      endcase
    end else if (erase_busy_i) begin
      case (op_i)
        OP_STATUS, OP_SUSP: ok_o = 1'b1;
        default: ok_o = 1'b0;
      endcase
    end else if (prog_busy_i) begin
      ok_o = (op_i == OP_STATUS);
    end else begin
      case (op_i)
        OP_RESET, OP_ID, OP_PROG, OP_CHIP, OP_SECT,
        OP_STATUS, OP_CLEAR, OP_ABORT: ok_o = 1'b1;
        default: ok_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cmdec_outreg.sv
module cmdec_outreg
  import cmdec_pkg::*;
#(
  parameter int SECT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              ok_i,
  input  op_e               op_i,
  input  logic [SECT_W-1:0] sector_i,
  output rmode_e            mode_o,
  output logic [PULSE_N-1:0] pulse_o,
  output logic [SECT_W-1:0] sector_o
);

  logic               take;
  logic [PULSE_N-1:0] pulse_d;

  assign take = fire_i && ok_i;

  always_comb begin
    pulse_d = '0;
    case (op_i)
      OP_PROG:   pulse_d[PB_PROG]   = 1'b1;
      OP_CHIP:   pulse_d[PB_CHIP]   = 1'b1;
      OP_SECT:   pulse_d[PB_SECT]   = 1'b1;
      OP_SUSP:   pulse_d[PB_SUSP]   = 1'b1;
      OP_RESUME: pulse_d[PB_RESUME] = 1'b1;
      OP_CLEAR:  pulse_d[PB_CLEAR]  = 1'b1;
      OP_ABORT:  pulse_d[PB_ABORT]  = 1'b1;
      default:   pulse_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= RM_ARRAY;
      pulse_o  <= '0;
      sector_o <= '0;
    end else begin
      pulse_o <= take ? pulse_d : '0;
      if (take) begin
        case (op_i)
          OP_RESET, OP_ABORT: mode_o <= RM_ARRAY;
          OP_ID:              mode_o <= RM_ID;
          OP_CLEAR, OP_NONE:  mode_o <= mode_o;
          default:            mode_o <= RM_STATUS;
        endcase
        if (op_i == OP_SECT) sector_o <= sector_i;
      end
    end
  end

endmodule

// File: rtl/cmdec_id.sv
module cmdec_id #(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hF9
) (
  input  logic       sel_i,
  output logic [7:0] data_o
);

  assign data_o = sel_i ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import cmdec_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              prog_busy_i,
  input  logic              erase_busy_i,
  input  logic              erase_susp_i,
  input  logic              id_sel_i,
  output logic [1:0]        read_mode_o,
  output logic [7:0]        id_data_o,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              sect_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              clr_status_o,
  output logic              abort_o,
  output logic [SECT_W-1:0] sector_o
);

  localparam int CMP_W = 15;

  logic               fire, ok, setup_ok;
  op_e                op;
  rmode_e             mode;
  logic [PULSE_N-1:0] pulse;

  cmdec_seq #(
    .ADDR_W (ADDR_W),
    .CMP_W  (CMP_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .setup_ok_i (setup_ok),
    .fire_o     (fire),
    .op_o       (op)
  );

  cmdec_gate u_gate (
    .op_i         (op),
    .prog_busy_i  (prog_busy_i),
    .erase_busy_i (erase_busy_i),
    .erase_susp_i (erase_susp_i),
    .ok_o         (ok),
    .setup_ok_o   (setup_ok)
  );

  cmdec_outreg #(
    .SECT_W (SECT_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .ok_i     (ok),
    .op_i     (op),
    .sector_i (wr_addr_i[SECT_LSB +: SECT_W]),
    .mode_o   (mode),
    .pulse_o  (pulse),
    .sector_o (sector_o)
  );

  cmdec_id u_id (
    .sel_i  (id_sel_i),
    .data_o (id_data_o)
  );

  assign read_mode_o  = mode;
  assign prog_start_o = pulse[PB_PROG];
  assign chip_erase_o = pulse[PB_CHIP];
  assign sect_erase_o = pulse[PB_SECT];
  assign suspend_o    = pulse[PB_SUSP];
  assign resume_o     = pulse[PB_RESUME];
  assign clr_status_o = pulse[PB_CLEAR];
  assign abort_o      = pulse[PB_ABORT];

endmodule

// File: rtl/cmd_unlock_decoder_chk.sv
module cmd_unlock_decoder_chk #(
  parameter int SECT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              prog_busy_i,
  input logic              erase_busy_i,
  input logic              erase_susp_i,
  input logic [1:0]        read_mode_o,
  input logic              prog_start_o,
  input logic              chip_erase_o,
  input logic              sect_erase_o,
  input logic              suspend_o,
  input logic              resume_o,
  input logic              clr_status_o,
  input logic              abort_o,
  input logic [SECT_W-1:0] sector_o
);

  logic [6:0] pl;
  assign pl = {abort_o, clr_status_o, resume_o, suspend_o,
               sect_erase_o, chip_erase_o, prog_start_o};

  // R11
  pulse_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pl));

  // R11
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl != 7'd0) |=> (pl == 7'd0));

  // R2
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(read_mode_o) && pl == 7'd0));

  // R5
  sector_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sect_erase_o |-> $stable(sector_o));

  // R7
  prog_busy_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_busy_i && !erase_busy_i && !erase_susp_i) |=> (pl == 7'd0));

  // R8
  erase_busy_only_susp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_busy_i && !erase_susp_i) |=> ((pl & 7'b111_0111) == 7'd0));

  // R9
  susp_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_susp_i |=> ((pl & 7'b010_1111) == 7'd0));

endmodule

bind cmd_unlock_decoder cmd_unlock_decoder_chk #(.SECT_W(SECT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .prog_busy_i  (prog_busy_i),
  .erase_busy_i (erase_busy_i),
  .erase_susp_i (erase_susp_i),
  .read_mode_o  (read_mode_o),
  .prog_start_o (prog_start_o),
  .chip_erase_o (chip_erase_o),
  .sect_erase_o (sect_erase_o),
  .suspend_o    (suspend_o),
  .resume_o     (resume_o),
  .clr_status_o (clr_status_o),
  .abort_o      (abort_o),
  .sector_o     (sector_o)
);

// File: tb/cmd_unlock_decoder_bench.sv
`timescale 1ns/1ps
module cmd_unlock_decoder_bench;

  localparam int K_RESET = 0, K_ID = 1, K_PROG = 2, K_SUSP = 3, K_RESUME = 4,
                 K_STATUS = 5, K_CLEAR = 6, K_ABORT = 7, K_CHIP = 8, K_SECT = 9;
  localparam int S_IDLE = 0, S_PROG = 1, S_ERASE = 2, S_SUSP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [20:0] addr = '0;
  logic [7:0]  data = '0;
  logic        pb = 1'b0, eb = 1'b0, es = 1'b0, idsel = 1'b0;
  logic [1:0]  mode;
  logic [7:0]  idd;
  logic        p_prog, p_chip, p_sect, p_susp, p_res, p_clr, p_abort;
  logic [4:0]  sect;
  logic [6:0]  pulses;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_mode = 0;
  int exp_sect = 0;

  always #2.5 clk = ~clk;

  cmd_unlock_decoder u_cmd_unlock_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .prog_busy_i(pb), .erase_busy_i(eb),
    .erase_susp_i(es), .id_sel_i(idsel), .read_mode_o(mode),
    .id_data_o(idd), .prog_start_o(p_prog), .chip_erase_o(p_chip),
    .sect_erase_o(p_sect), .suspend_o(p_susp), .resume_o(p_res),
    .clr_status_o(p_clr), .abort_o(p_abort), .sector_o(sect)
  );

  assign pulses = {p_abort, p_clr, p_res, p_susp, p_sect, p_chip, p_prog};

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog (R1..R12 run) actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] code_of(input int op);
    case (op)
      K_RESET: return 8'hF0;  K_ID: return 8'h90;     K_PROG: return 8'hA0;
      K_SUSP: return 8'hB0;   K_RESUME: return 8'hD0; K_STATUS: return 8'h70;
      K_CLEAR: return 8'h50;  K_ABORT: return 8'hE0;  default: return 8'h80;
    endcase
  endfunction

  function automatic bit allowed(input int op, input int st);
    case (st)
      S_SUSP:  return op inside {K_RESET, K_STATUS, K_ABORT, K_RESUME};
      S_ERASE: return op inside {K_STATUS, K_SUSP};
      S_PROG:  return op == K_STATUS;
      default: return !(op inside {K_SUSP, K_RESUME});
    endcase
  endfunction

  function automatic int pulse_of(input int op);
    case (op)
      K_PROG: return 1;   K_CHIP: return 2;    K_SECT: return 4;
      K_SUSP: return 8;   K_RESUME: return 16; K_CLEAR: return 32;
      K_ABORT: return 64; default: return 0;
    endcase
  endfunction

  function automatic int mode_of(input int op, input int cur);
    case (op)
      K_RESET, K_ABORT: return 0;
      K_ID: return 2;
      K_CLEAR: return cur;
      default: return 1;
    endcase
  endfunction

  function automatic string req_of(input int op, input int st, input int brk);
    if (brk != 0) return "R6";
    if (st == S_PROG) return "R7";
    if (st == S_ERASE) return "R8";
    if (st == S_SUSP) return "R9";
    if (op == K_CHIP) return "R4";
    if (op == K_SECT) return "R5";
    if (op == K_CLEAR) return "R12";
    return "R2";
  endfunction

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // brk: 0 = complete sequence, k = corrupt write k and stop there
  task automatic run_cmd(input int op, input int st, input int brk,
                         input logic [5:0] hi, input logic [4:0] sc,
                         input logic [15:0] lo);
    int n;
    logic [20:0] a;
    logic [7:0]  d;
    bit ok;
    string rq;
    pb = (st == S_PROG);
    eb = (st == S_ERASE) || (st == S_SUSP);
    es = (st == S_SUSP);
    n = (op >= K_CHIP) ? 6 : 3;
    for (int k = 1; k <= n; k++) begin
      case (k)
        1, 3, 4: begin a = {hi, 15'h5555}; d = (k == 3) ? code_of(op) : 8'hAA; end
        2, 5:    begin a = {hi, 15'h2AAA}; d = 8'h55; end
        default: begin
          if (op == K_CHIP) begin a = {hi, 15'h5555}; d = 8'h10; end
          else begin a = {sc, lo}; d = 8'h30; end
        end
      endcase
      if (k == brk) d = d ^ 8'h01;
      wr(a, d);
      if (k == brk) break;
    end
    ok = (brk == 0) && allowed(op, st);
    rq = req_of(op, st, brk);
    if (ok) begin
      exp_mode = mode_of(op, exp_mode);
      if (op == K_SECT) exp_sect = int'(sc);
    end
    chk({rq, " pulses"}, int'(pulses), ok ? pulse_of(op) : 0);
    chk({rq, " read mode"}, int'(mode), exp_mode);
    chk({rq, " sector"}, int'(sect), exp_sect);
    @(negedge clk);
    chk("R11 pulse width", int'(pulses), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    @(negedge clk); @(negedge clk);
    // R1
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset pulses", int'(pulses), 0);
    chk("R1 reset sector", int'(sect), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    idsel = 1'b0; #1 chk("R10 id offset 0", int'(idd), 8'hC2);
    idsel = 1'b1; #1 chk("R10 id offset 1", int'(idd), 8'hF9);
    @(negedge clk);

    run_cmd(K_ID, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_RESET, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    // R3: high address bits set on all unlock writes
    run_cmd(K_STATUS, S_IDLE, 0, 6'h3F, 5'h0, 16'h0);
    run_cmd(K_PROG, S_IDLE, 0, 6'h2A, 5'h0, 16'h0);
    // R12: clear keeps status and id modes
    run_cmd(K_CLEAR, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_ID, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_CLEAR, S_IDLE, 0, 6'h11, 5'h0, 16'h0);
    run_cmd(K_ABORT, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    // R4, R5
    run_cmd(K_CHIP, S_IDLE, 0, 6'h15, 5'h0, 16'h0);
    run_cmd(K_RESET, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_SECT, S_IDLE, 0, 6'h00, 5'h1F, 16'h1234);
    run_cmd(K_SECT, S_IDLE, 0, 6'h00, 5'h00, 16'hFFFF);
    run_cmd(K_SECT, S_IDLE, 0, 6'h00, 5'h0A, 16'h5555);
    // R6: break at every position
    run_cmd(K_RESET, S_IDLE, 0, 6'h00, 5'h0, 16'h0);
    for (int b = 1; b <= 3; b++) run_cmd(K_PROG, S_IDLE, b, 6'h00, 5'h0, 16'h0);
    for (int b = 1; b <= 6; b++) run_cmd(K_SECT, S_IDLE, b, 6'h00, 5'h13, 16'h0);
    for (int b = 4; b <= 6; b++) run_cmd(K_CHIP, S_IDLE, b, 6'h00, 5'h0, 16'h0);
    // R7
    run_cmd(K_RESET, S_PROG, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_STATUS, S_PROG, 0, 6'h00, 5'h0, 16'h0);
    // R8
    run_cmd(K_PROG, S_ERASE, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_SUSP, S_ERASE, 0, 6'h00, 5'h0, 16'h0);
    // R9
    run_cmd(K_RESET, S_SUSP, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_CLEAR, S_SUSP, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_RESUME, S_SUSP, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_ABORT, S_SUSP, 0, 6'h00, 5'h0, 16'h0);
    // R12: erase setup while busy is dropped
    run_cmd(K_SECT, S_ERASE, 0, 6'h00, 5'h07, 16'h0);
    run_cmd(K_CHIP, S_SUSP, 0, 6'h00, 5'h0, 16'h0);
    run_cmd(K_SECT, S_PROG, 0, 6'h00, 5'h03, 16'h0);

    for (int i = 0; i < 400; i++) begin
      int op, st, brk, n;
      op  = int'($urandom_range(0, 9));
      st  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 3)) : S_IDLE;
      n   = (op >= K_CHIP) ? 6 : 3;
      brk = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, n)) : 0;
      run_cmd(op, st, brk, 6'($urandom), 5'($urandom), 16'($urandom));
    end

    summary();
    $finish;
  end

endmodule